// File: doc/BRIEF.md
# Ethernet DMA Control and Status Register Bank

This block is the host-visible register file of a descriptor-driven Ethernet DMA engine. A simple 32-bit host bus reaches it with a byte address. The bank drops the two low address bits to form a word index and decodes that index into a small set of registers:

- bus mode
- DMA control
- interrupt enable
- event status
- the transmit and receive descriptor list bases
- the live transmit and receive descriptor pointers
- a read-only version word

The transmit and receive engines report what happened through single-cycle event pulses. Each pulse sets the matching status cause bit and the matching summary bit. Software acknowledges causes by writing ones to the status register. The block drives one level interrupt and two enable outputs. A write to the transmit poll-demand location is not stored. It produces a one-cycle strobe that tells the transmit engine to scan its descriptors.

Writing a list base also restarts the matching live pointer at that base. The engines can load the live pointers as they walk the descriptor ring.

Top module: `dma_csr_bank`

## Requirements
- R1: After reset every register reads zero except the version word. `irq`, `txPollStrobe`, `rxEnable` and `txEnable` are low.
- R2: The register index is `hostAddr >> 2`, so the two low address bits have no effect on reads or writes. Word indices:
  - 0 bus mode
  - 1 transmit poll demand
  - 2 receive list base
  - 3 transmit list base
  - 4 status
  - 5 control
  - 6 interrupt enable
  - 7 current transmit pointer (read-only)
  - 8 current receive pointer (read-only)
  - 9 version (read-only)
- R3: A write to status clears each bit written as one and leaves each bit written as zero unchanged.
- R4: Engine events set status bits on the next clock edge:
  - tx done sets bits 0 and 16
  - tx stopped sets bits 1 and 15
  - tx buffer unavailable sets bits 2 and 15
  - rx done sets bits 6 and 16
  - rx buffer unavailable sets bits 7 and 15
  
  When a status write and an event hit the same bit in the same cycle, the bit ends up set.
- R5: `irq` is high exactly when some bit of (status AND interrupt enable) is set, one cycle after the write or event that changes either register.
- R6: A write to the receive (transmit) list base stores the value and also loads the current receive (transmit) pointer with it. A host base write wins over an engine pointer load in the same cycle.
- R7: When `rxPtrLoad` (`txPtrLoad`) is high and no base write targets the same pointer, the current pointer takes `rxPtrValue` (`txPtrValue`) on the next edge.
- R8: Bit 0 of bus mode is never stored and always reads zero. The other bits store the written value.
- R9: The version word always reads 0x00001012, whatever has been written to it.
- R10: A write to the poll-demand index raises `txPollStrobe` for exactly the cycle after the write edge. The location reads zero.
- R11: `rxEnable` follows bit 1 of the control register and `txEnable` follows bit 13.
- R12: Reads of unmapped indices (10 and above) return zero. Writes there, and writes to the read-only indices 7 to 9, change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostSel | input | 1 | Host access valid this cycle |
| hostWr | input | 1 | 1 write, 0 read |
| hostAddr | input | ADDR_W | Byte address |
| hostWdata | input | DATA_W | Write data |
| hostRdata | output | DATA_W | Read data, combinational, zero when no read |
| evTxDone | input | 1 | Transmit frame completed |
| evTxStop | input | 1 | Transmit process stopped |
| evTxUnavail | input | 1 | Transmit descriptor not owned |
| evRxDone | input | 1 | Receive frame completed |
| evRxUnavail | input | 1 | Receive descriptor not owned |
| txPtrLoad | input | 1 | Load current transmit pointer |
| txPtrValue | input | DATA_W | New transmit pointer |
| rxPtrLoad | input | 1 | Load current receive pointer |
| rxPtrValue | input | DATA_W | New receive pointer |
| irq | output | 1 | Level interrupt |
| txPollStrobe | output | 1 | One-cycle transmit scan request |
| rxEnable | output | 1 | Receive enabled |
| txEnable | output | 1 | Transmit enabled |
| curTxPtr | output | DATA_W | Current transmit descriptor pointer |
| curRxPtr | output | DATA_W | Current receive descriptor pointer |

## Verification
The bench builds the bank with its defaults, `ADDR_W` = 12 and `DATA_W` = 32. This gives a 10-bit word index, so random accesses reach every mapped index, the unmapped indices just above them and the top index 1023. Every status and enable bit is wide enough for the stated positions.

Random writes with random low address bits, overlapped with random event pulses and pointer loads, exercise the collisions that matter:
- a status clear against a set in the same cycle
- a base write against a pointer load in the same cycle

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;

  localparam int IDX_BUS    = 0;
  localparam int IDX_POLL   = 1;
  localparam int IDX_RXBASE = 2;
  localparam int IDX_TXBASE = 3;
  localparam int IDX_STATUS = 4;
  localparam int IDX_CTRL   = 5;
  localparam int IDX_INTEN  = 6;
  localparam int IDX_CURTX  = 7;
  localparam int IDX_CURRX  = 8;
  localparam int IDX_VER    = 9;

  localparam int BIT_TX_DONE    = 0;
  localparam int BIT_TX_STOP    = 1;
  localparam int BIT_TX_UNAVAIL = 2;
  localparam int BIT_RX_DONE    = 6;
  localparam int BIT_RX_UNAVAIL = 7;
  localparam int BIT_ABN_SUM    = 15;
  localparam int BIT_NRM_SUM    = 16;

  localparam int BIT_RX_EN = 1;
  localparam int BIT_TX_EN = 13;

  localparam logic [31:0] VERSION_WORD = 32'h0000_1012;

  typedef struct packed {
    logic busMode;
    logic rxBase;
    logic txBase;
    logic status;
    logic control;
    logic intEn;
  } csr_wr_t;

  typedef enum logic [3:0] {
    RD_NONE, RD_BUS, RD_RXBASE, RD_TXBASE, RD_STATUS,
    RD_CTRL, RD_INTEN, RD_CURTX, RD_CURRX, RD_VER
  } csr_rd_e;

endpackage

// File: rtl/dma_csr_ctrl.sv
module dma_csr_ctrl
  import dma_csr_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostSel,
  input  logic             hostWr,
  input  logic [IDX_W-1:0] regIdx,
  output csr_wr_t          wrStb,
  output csr_rd_e          rdSel,
  output logic             pollStrobe
);

  logic wrEn;
  logic rdEn;
  logic pollHit;

  assign wrEn = hostSel & hostWr;
  assign rdEn = hostSel & ~hostWr;

  always_comb begin
    wrStb   = '0;
    rdSel   = RD_NONE;
    pollHit = 1'b0;
    case (regIdx)
      IDX_W'(IDX_BUS):    begin rdSel = RD_BUS;    wrStb.busMode = wrEn; end
      IDX_W'(IDX_POLL):   pollHit = wrEn;
      IDX_W'(IDX_RXBASE): begin rdSel = RD_RXBASE; wrStb.rxBase  = wrEn; end
      IDX_W'(IDX_TXBASE): begin rdSel = RD_TXBASE; wrStb.txBase  = wrEn; end
      IDX_W'(IDX_STATUS): begin rdSel = RD_STATUS; wrStb.status  = wrEn; end
      IDX_W'(IDX_CTRL):   begin rdSel = RD_CTRL;   wrStb.control = wrEn; end
      IDX_W'(IDX_INTEN):  begin rdSel = RD_INTEN;  wrStb.intEn   = wrEn; end
      IDX_W'(IDX_CURTX):  rdSel = RD_CURTX;
      IDX_W'(IDX_CURRX):  rdSel = RD_CURRX;
      IDX_W'(IDX_VER):    rdSel = RD_VER;
      default: ;
    endcase
    if (!rdEn) rdSel = RD_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) pollStrobe <= 1'b0;
    else       pollStrobe <= pollHit;
  end

  // R10
  poll_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    pollStrobe |-> $past(hostSel && hostWr && (regIdx == IDX_W'(IDX_POLL))));

endmodule

// File: rtl/dma_csr_datapath.sv
module dma_csr_datapath
  import dma_csr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  csr_wr_t           wrStb,
  input  csr_rd_e           rdSel,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  input  logic              evTxDone,
  input  logic              evTxStop,
  input  logic              evTxUnavail,
  input  logic              evRxDone,
  input  logic              evRxUnavail,
  input  logic              txPtrLoad,
  input  logic [DATA_W-1:0] txPtrValue,
  input  logic              rxPtrLoad,
  input  logic [DATA_W-1:0] rxPtrValue,
  output logic              irq,
  output logic              rxEnable,
  output logic              txEnable,
  output logic [DATA_W-1:0] curTxPtr,
  output logic [DATA_W-1:0] curRxPtr
);

  logic [DATA_W-1:0] busModeQ, rxBaseQ, txBaseQ, statusQ, controlQ, intEnQ;
  logic [DATA_W-1:0] curTxQ, curRxQ;
  logic [DATA_W-1:0] setMask, clrMask;

  always_comb begin
    setMask = '0;
    if (evTxDone)    begin setMask[BIT_TX_DONE]    = 1'b1; setMask[BIT_NRM_SUM] = 1'b1; end
    if (evRxDone)    begin setMask[BIT_RX_DONE]    = 1'b1; setMask[BIT_NRM_SUM] = 1'b1; end
    if (evTxStop)    begin setMask[BIT_TX_STOP]    = 1'b1; setMask[BIT_ABN_SUM] = 1'b1; end
    if (evTxUnavail) begin setMask[BIT_TX_UNAVAIL] = 1'b1; setMask[BIT_ABN_SUM] = 1'b1; end
    if (evRxUnavail) begin setMask[BIT_RX_UNAVAIL] = 1'b1; setMask[BIT_ABN_SUM] = 1'b1; end
  end

  assign clrMask = wrStb.status ? hostWdata : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busModeQ <= '0;
      rxBaseQ  <= '0;
      txBaseQ  <= '0;
      statusQ  <= '0;
      controlQ <= '0;
      intEnQ   <= '0;
      curTxQ   <= '0;
      curRxQ   <= '0;
    end else begin
      if (wrStb.busMode) busModeQ <= {hostWdata[DATA_W-1:1], 1'b0};
      if (wrStb.control) controlQ <= hostWdata;
      if (wrStb.intEn)   intEnQ   <= hostWdata;
      statusQ <= (statusQ & ~clrMask) | setMask;
      if (wrStb.rxBase) begin
        rxBaseQ <= hostWdata;
        curRxQ  <= hostWdata;
      end else if (rxPtrLoad) begin
        curRxQ  <= rxPtrValue;
      end
      if (wrStb.txBase) begin
        txBaseQ <= hostWdata;
        curTxQ  <= hostWdata;
      end else if (txPtrLoad) begin
        curTxQ  <= txPtrValue;
      end
    end
  end

  always_comb begin
    case (rdSel)
      RD_BUS:    hostRdata = busModeQ;
      RD_RXBASE: hostRdata = rxBaseQ;
      RD_TXBASE: hostRdata = txBaseQ;
      RD_STATUS: hostRdata = statusQ;
      RD_CTRL:   hostRdata = controlQ;
      RD_INTEN:  hostRdata = intEnQ;
      RD_CURTX:  hostRdata = curTxQ;
      RD_CURRX:  hostRdata = curRxQ;
      RD_VER:    hostRdata = DATA_W'(VERSION_WORD);
      default:   hostRdata = '0;
    endcase
  end

  assign irq      = |(statusQ & intEnQ);
  assign rxEnable = controlQ[BIT_RX_EN];
  assign txEnable = controlQ[BIT_TX_EN];
  assign curTxPtr = curTxQ;
  assign curRxPtr = curRxQ;

  // R3
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb.status && !evTxDone && !evTxStop && !evTxUnavail && !evRxDone && !evRxUnavail)
    |=> statusQ == ($past(statusQ) & ~$past(hostWdata)));

  // R4
  tx_done_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    evTxDone |=> (statusQ[BIT_TX_DONE] && statusQ[BIT_NRM_SUM]));

  // R4
  rx_unavail_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    evRxUnavail |=> (statusQ[BIT_RX_UNAVAIL] && statusQ[BIT_ABN_SUM]));

  // R5
  irq_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (statusQ != '0 && intEnQ != '0));

  // R6
  rx_base_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrStb.rxBase |=> curRxQ == $past(hostWdata));

  // R7
  tx_ptr_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txPtrLoad && !wrStb.txBase) |=> curTxQ == $past(txPtrValue));

endmodule

// File: rtl/dma_csr_bank.sv
module dma_csr_bank
  import dma_csr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostSel,
  input  logic              hostWr,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  input  logic              evTxDone,
  input  logic              evTxStop,
  input  logic              evTxUnavail,
  input  logic              evRxDone,
  input  logic              evRxUnavail,
  input  logic              txPtrLoad,
  input  logic [DATA_W-1:0] txPtrValue,
  input  logic              rxPtrLoad,
  input  logic [DATA_W-1:0] rxPtrValue,
  output logic              irq,
  output logic              txPollStrobe,
  output logic              rxEnable,
  output logic              txEnable,
  output logic [DATA_W-1:0] curTxPtr,
  output logic [DATA_W-1:0] curRxPtr
);

  localparam int IDX_W = ADDR_W - 2;

  csr_wr_t          wrStb;
  csr_rd_e          rdSel;
  logic [IDX_W-1:0] regIdx;
  logic [1:0]       unusedAddrBits;

  assign regIdx         = hostAddr[ADDR_W-1:2];
  assign unusedAddrBits = hostAddr[1:0];

  dma_csr_ctrl #(.IDX_W(IDX_W)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .hostSel    (hostSel),
    .hostWr     (hostWr),
    .regIdx     (regIdx),
    .wrStb      (wrStb),
    .rdSel      (rdSel),
    .pollStrobe (txPollStrobe)
  );

  dma_csr_datapath #(.DATA_W(DATA_W)) uData (
    .clk         (clk),
    .rstN        (rstN),
    .wrStb       (wrStb),
    .rdSel       (rdSel),
    .hostWdata   (hostWdata),
    .hostRdata   (hostRdata),
    .evTxDone    (evTxDone),
    .evTxStop    (evTxStop),
    .evTxUnavail (evTxUnavail),
    .evRxDone    (evRxDone),
    .evRxUnavail (evRxUnavail),
    .txPtrLoad   (txPtrLoad),
    .txPtrValue  (txPtrValue),
    .rxPtrLoad   (rxPtrLoad),
    .rxPtrValue  (rxPtrValue),
    .irq         (irq),
    .rxEnable    (rxEnable),
    .txEnable    (txEnable),
    .curTxPtr    (curTxPtr),
    .curRxPtr    (curRxPtr)
  );

endmodule

// File: tb/tb_dma_csr_bank.sv
module tb_dma_csr_bank;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostSel = 1'b0, hostWr = 1'b0;
  logic [11:0] hostAddr = '0;
  logic [31:0] hostWdata = '0;
  logic [31:0] hostRdata;
  logic        evTxDone = 0, evTxStop = 0, evTxUnavail = 0, evRxDone = 0, evRxUnavail = 0;
  logic        txPtrLoad = 0, rxPtrLoad = 0;
  logic [31:0] txPtrValue = '0, rxPtrValue = '0;
  logic        irq, txPollStrobe, rxEnable, txEnable;
  logic [31:0] curTxPtr, curRxPtr;

  int tests = 0;
  int fails = 0;

  logic [31:0] mBus, mRxB, mTxB, mStat, mCtrl, mIen, mCurTx, mCurRx;

  always #5 clk = ~clk;

  dma_csr_bank dut (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWr(hostWr),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .evTxDone(evTxDone), .evTxStop(evTxStop), .evTxUnavail(evTxUnavail),
    .evRxDone(evRxDone), .evRxUnavail(evRxUnavail),
    .txPtrLoad(txPtrLoad), .txPtrValue(txPtrValue),
    .rxPtrLoad(rxPtrLoad), .rxPtrValue(rxPtrValue),
    .irq(irq), .txPollStrobe(txPollStrobe), .rxEnable(rxEnable),
    .txEnable(txEnable), .curTxPtr(curTxPtr), .curRxPtr(curRxPtr)
  );

  function automatic logic [31:0] expRead(int idx);
    case (idx)
      0: return mBus;
      2: return mRxB;
      3: return mTxB;
      4: return mStat;
      5: return mCtrl;
      6: return mIen;
      7: return mCurTx;
      8: return mCurRx;
      9: return 32'h0000_1012;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] evMask(logic [4:0] ev);
    logic [31:0] m = '0;
    if (ev[0]) begin m[0] = 1; m[16] = 1; end
    if (ev[1]) begin m[1] = 1; m[15] = 1; end
    if (ev[2]) begin m[2] = 1; m[15] = 1; end
    if (ev[3]) begin m[6] = 1; m[16] = 1; end
    if (ev[4]) begin m[7] = 1; m[15] = 1; end
    return m;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic readChk(string req, int idx, logic [1:0] low);
    @(negedge clk);
    hostSel = 1; hostWr = 0; hostAddr = {idx[9:0], low};
    #1;
    check(req, hostRdata, expRead(idx));
    hostSel = 0;
  endtask

  // One bus/event cycle; the model is advanced as the design should be.
  task automatic cycle(logic doWr, int idx, logic [1:0] low, logic [31:0] data,
                       logic [4:0] ev, logic tLd, logic [31:0] tVal,
                       logic rLd, logic [31:0] rVal);
    logic pollExp;
    logic wrRx, wrTx;
    @(negedge clk);
    hostSel = doWr; hostWr = doWr; hostAddr = {idx[9:0], low}; hostWdata = data;
    {evRxUnavail, evRxDone, evTxUnavail, evTxStop, evTxDone} = ev;
    txPtrLoad = tLd; txPtrValue = tVal; rxPtrLoad = rLd; rxPtrValue = rVal;
    @(negedge clk);
    hostSel = 0; hostWr = 0;
    {evRxUnavail, evRxDone, evTxUnavail, evTxStop, evTxDone} = '0;
    txPtrLoad = 0; rxPtrLoad = 0;
    pollExp = doWr && idx == 1;
    wrRx = doWr && idx == 2;
    wrTx = doWr && idx == 3;
    if (doWr) begin
      case (idx)
        0: mBus = data & ~32'h1;
        2: begin mRxB = data; mCurRx = data; end
        3: begin mTxB = data; mCurTx = data; end
        5: mCtrl = data;
        6: mIen = data;
        default: ;
      endcase
    end
    mStat = (mStat & ~((doWr && idx == 4) ? data : 32'h0)) | evMask(ev);
    if (tLd && !wrTx) mCurTx = tVal;
    if (rLd && !wrRx) mCurRx = rVal;
    #1;
    check("R10 poll strobe", {31'h0, txPollStrobe}, {31'h0, pollExp});
    check("R5 irq", {31'h0, irq}, {31'h0, |(mStat & mIen)});
    check("R11 enables", {30'h0, txEnable, rxEnable}, {30'h0, mCtrl[13], mCtrl[1]});
    check("R7 ptr outputs", curTxPtr ^ curRxPtr, mCurTx ^ mCurRx);
  endtask

  task automatic fullChk(string req);
    for (int i = 0; i < 12; i++) readChk(req, i, 2'(i));
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    {mBus, mRxB, mTxB, mStat, mCtrl, mIen, mCurTx, mCurRx} = '0;
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    // R1 reset state
    check("R1 irq/strobe/enables", {28'h0, irq, txPollStrobe, rxEnable, txEnable}, 32'h0);
    fullChk("R1 reset readback");

    // R9 version is constant, R12 read-only writes ignored
    cycle(1, 9, 0, 32'hFFFF_FFFF, 0, 0, 0, 0, 0);
    readChk("R9 version", 9, 0);
    cycle(1, 7, 0, 32'h1234_5678, 0, 0, 0, 0, 0);
    readChk("R12 ro curtx", 7, 0);
    cycle(1, 500, 0, 32'hDEAD_BEEF, 0, 0, 0, 0, 0);
    readChk("R12 unmapped", 500, 0);
    readChk("R12 top index", 1023, 3);

    // R8 soft reset bit not stored
    cycle(1, 0, 0, 32'hFFFF_FFFF, 0, 0, 0, 0, 0);
    readChk("R8 bus mode", 0, 0);

    // R2 low address bits ignored
    cycle(1, 5, 2'b11, 32'h0000_2002, 0, 0, 0, 0, 0);
    readChk("R2 index decode", 5, 2'b01);

    // R10 poll demand: strobe, no storage
    cycle(1, 1, 0, 32'hFFFF_FFFF, 0, 0, 0, 0, 0);
    readChk("R10 poll reads zero", 1, 0);

    // R6 base loads pointer; host wins over engine load
    cycle(1, 2, 0, 32'h0000_1000, 0, 0, 0, 1, 32'h0000_5555);
    readChk("R6 rx base", 2, 0);
    readChk("R6 rx cur ptr", 8, 0);
    cycle(0, 0, 0, 0, 0, 1, 32'h0000_2040, 0, 0);
    readChk("R7 tx ptr load", 7, 0);

    // R4 events and set-wins
    cycle(0, 0, 0, 0, 5'b11111, 0, 0, 0, 0);
    readChk("R4 all events", 4, 0);
    cycle(1, 4, 0, 32'hFFFF_FFFF, 5'b00001, 0, 0, 0, 0);
    readChk("R4 set wins over clear", 4, 0);
    // R3 partial clear
    cycle(1, 4, 0, 32'h0000_0001, 0, 0, 0, 0, 0);
    readChk("R3 w1c partial", 4, 0);

    // R5 interrupt enable
    cycle(1, 6, 0, 32'h0000_0001, 0, 0, 0, 0, 0);
    cycle(0, 0, 0, 0, 5'b00001, 0, 0, 0, 0);
    cycle(1, 6, 0, 32'h0001_0000, 0, 0, 0, 0, 0);
    cycle(1, 4, 0, 32'hFFFF_FFFF, 0, 0, 0, 0, 0);

    // random mix
    for (int n = 0; n < 600; n++) begin
      int idx;
      logic doWr;
      logic [4:0] ev;
      logic [31:0] data;
      idx  = ($urandom % 10 == 0) ? int'($urandom % 1024) : int'($urandom % 12);
      doWr = ($urandom % 4) != 0;
      ev   = ($urandom % 3 == 0) ? 5'($urandom) : 5'h0;
      data = $urandom;
      cycle(doWr, idx, 2'($urandom), data, ev,
            ($urandom % 5 == 0), $urandom, ($urandom % 5 == 0), $urandom);
      readChk("R3 R4 R6 random readback", int'($urandom % 12), 2'($urandom));
      if (n % 100 == 99) fullChk("R12 R2 random full readback");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule